// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block follows the clock and data lines of a two-wire I2C bus and keeps a flag that tells whether the bus is occupied. The flag is set when data falls while the clock is high, which is a start condition. It is cleared when data rises while the clock is high, which is a stop condition. Both lines pass through a synchronizer before any edge is judged. The flag changes only because of what the bus does.

A host uses a single register write to ask for a bus condition. The write carries a busy bit and a clock-hold bit. When the clock-hold bit is 0 and the busy bit is 1, the write asks for a start condition. If the bus is already busy, that request is a repeated start. When both bits are 0, the write asks for a stop condition. Any write with the clock-hold bit at 1 asks for nothing.

Each accepted request gives a one-cycle pulse to a separate bit engine, which drives the lines. A pending flag stays set until the matching condition is seen on the bus. A start request needs both master and transmit mode. A stop request needs master mode. In slave mode every write to the busy bit is ignored.

Top module: `i2c_busy_monitor`

## Requirements
- R1: After reset the busy flag, both request pulses, the repeated-start flag and both pending flags read 0.
- R2: A falling SDA with SCL held high sets the busy flag. The flag reads 1 three clock cycles after the line change, and still reads its old value two cycles after it.
- R3: A rising SDA with SCL held high clears the busy flag, with the same three-cycle latency as R2.
- R4: SDA changes while SCL is low are not conditions. SCL changes are not conditions either. The busy flag keeps its value.
- R5: A one-cycle write with busy=1 and clock-hold=0, in master transmit mode, makes start_req high for exactly the one cycle after the write. start_rep is 0 in that cycle when the bus is free.
- R6: A start request made while the busy flag is 1 raises start_rep together with start_req.
- R7: A one-cycle write with busy=0 and clock-hold=0, in master mode (receive or transmit), makes stop_req high for exactly the one cycle after the write.
- R8: A write with master=0 gives no request pulse. A start write with master=1 and transmit=0 gives no start pulse.
- R9: A write with clock-hold=1 gives neither a start pulse nor a stop pulse.
- R10: A register write never changes the busy flag.
- R11: start_pend goes to 1 with an accepted start request and returns to 0 in the cycle the busy flag rises from a detected start. stop_pend behaves the same way for stop requests and detected stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset. Release is synchronized inside the block. |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| master_i | input | 1 | Master mode bit |
| transmit_i | input | 1 | Transmit mode bit |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_busy_i | input | 1 | Busy bit value carried by the write |
| wr_sclctl_i | input | 1 | Clock-hold bit value carried by the write |
| bus_busy_o | output | 1 | Bus busy flag |
| start_req_o | output | 1 | Start request pulse to the bit engine |
| start_rep_o | output | 1 | Qualifies start_req_o as a repeated start |
| stop_req_o | output | 1 | Stop request pulse to the bit engine |
| start_pend_o | output | 1 | Start requested and not yet seen on the bus |
| stop_pend_o | output | 1 | Stop requested and not yet seen on the bus |

## Verification
The hardest case to reach is a start request that arrives while the bus is already busy. That is the repeated start, and start_rep depends on it. Reaching it needs a start condition that was observed first and no stop after it.

The line state has to be moved with care. SDA must go to the right level while SCL is low, and only then can the edge happen with SCL high. Both line changes during this preparation are checked to leave the flag alone.

The bench keeps a model of the line levels and of the busy and pending state. Random writes and random bus conditions are interleaved, so requests meet the bus both free and busy. Directed cases cover the mode gating and the clock-hold bit.

// File: rtl/i2c_bbm_pkg.sv
package i2c_bbm_pkg;
  // Synchronized line pair; scl is the upper bit.
  typedef struct packed {
    logic scl;
    logic sda;
  } lines_t;
endpackage

// File: rtl/i2c_bbm_sync.sv
module i2c_bbm_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_i[b]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bbm_detect.sv
module i2c_bbm_detect
  import i2c_bbm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  lines_t cur_i,
  output logic   start_det_o,
  output logic   stop_det_o,
  output logic   busy_o
);
  lines_t prev_q;
  logic   busy_q, busy_d;
  logic   scl_hi;

  // A condition needs SCL high in both samples around the SDA edge.
  assign scl_hi      = cur_i.scl & prev_q.scl;
  assign start_det_o = scl_hi & prev_q.sda & ~cur_i.sda;
  assign stop_det_o  = scl_hi & ~prev_q.sda & cur_i.sda;

  always_comb begin
    busy_d = busy_q;
    if (start_det_o)     busy_d = 1'b1;
    else if (stop_det_o) busy_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '{scl: 1'b1, sda: 1'b1};
      busy_q <= 1'b0;
    end else begin
      prev_q <= cur_i;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  assert_busy_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_o |=> busy_o);
  assert_busy_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_o |=> !busy_o);
  // R4 and R10: the flag moves only after a detected condition.
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_det_o && !stop_det_o) |=> $stable(busy_o));
  assert_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_i.scl |-> !busy_d || busy_q);
endmodule

// File: rtl/i2c_bbm_req.sv
module i2c_bbm_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_busy_i,
  input  logic wr_sclctl_i,
  input  logic master_i,
  input  logic transmit_i,
  input  logic bus_busy_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  output logic start_req_o,
  output logic start_rep_o,
  output logic stop_req_o,
  output logic start_pend_o,
  output logic stop_pend_o
);
  logic cond_wr, start_acc, stop_acc;
  logic start_req_q, start_rep_q, stop_req_q, start_pend_q, stop_pend_q;
  logic start_req_d, start_rep_d, stop_req_d, start_pend_d, stop_pend_d;

  assign cond_wr   = wr_en_i & ~wr_sclctl_i;
  assign start_acc = cond_wr & wr_busy_i & master_i & transmit_i;
  assign stop_acc  = cond_wr & ~wr_busy_i & master_i;

  always_comb begin
    start_req_d  = start_acc;
    start_rep_d  = start_acc & bus_busy_i;
    stop_req_d   = stop_acc;
    start_pend_d = start_acc | (start_pend_q & ~start_det_i);
    stop_pend_d  = stop_acc  | (stop_pend_q  & ~stop_det_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_req_q  <= 1'b0;
      start_rep_q  <= 1'b0;
      stop_req_q   <= 1'b0;
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
    end else begin
      start_req_q  <= start_req_d;
      start_rep_q  <= start_rep_d;
      stop_req_q   <= stop_req_d;
      start_pend_q <= start_pend_d;
      stop_pend_q  <= stop_pend_d;
    end
  end

  assign start_req_o  = start_req_q;
  assign start_rep_o  = start_rep_q;
  assign stop_req_o   = stop_req_q;
  assign start_pend_o = start_pend_q;
  assign stop_pend_o  = stop_pend_q;

  assert_start_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> $past(wr_en_i && master_i && transmit_i && wr_busy_i));
  assert_stop_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |-> $past(wr_en_i && master_i && !wr_busy_i && !wr_sclctl_i));
  assert_sclctl_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sclctl_i) |=> (!start_req_o && !stop_req_o));
  assert_rep_qual_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rep_o |-> start_req_o);
  assert_pend_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> start_pend_o);
  assert_pend_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det_i && !start_acc) |=> !start_pend_o);
endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
  import i2c_bbm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic master_i,
  input  logic transmit_i,
  input  logic wr_en_i,
  input  logic wr_busy_i,
  input  logic wr_sclctl_i,
  output logic bus_busy_o,
  output logic start_req_o,
  output logic start_rep_o,
  output logic stop_req_o,
  output logic start_pend_o,
  output logic stop_pend_o
);
  localparam int LINES = $bits(lines_t);

  // Reset asserts at once and is released on a clock edge.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[RST_STAGES-1];

  logic [LINES-1:0] sync_q;
  lines_t           cur;
  logic             start_det, stop_det;

  i2c_bbm_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINES),
    .RST_VAL({LINES{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .d_i   ({scl_i, sda_i}),
    .q_o   (sync_q)
  );

  assign cur = lines_t'(sync_q);

  i2c_bbm_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .cur_i      (cur),
    .start_det_o(start_det),
    .stop_det_o (stop_det),
    .busy_o     (bus_busy_o)
  );

  i2c_bbm_req u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .wr_en_i     (wr_en_i),
    .wr_busy_i   (wr_busy_i),
    .wr_sclctl_i (wr_sclctl_i),
    .master_i    (master_i),
    .transmit_i  (transmit_i),
    .bus_busy_i  (bus_busy_o),
    .start_det_i (start_det),
    .stop_det_i  (stop_det),
    .start_req_o (start_req_o),
    .start_rep_o (start_rep_o),
    .stop_req_o  (stop_req_o),
    .start_pend_o(start_pend_o),
    .stop_pend_o (stop_pend_o)
  );

  assert_pulse_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $onehot0({start_req_o, stop_req_o}));
endmodule

// File: tb/i2c_busy_monitor_bench.sv
module i2c_busy_monitor_bench;
  logic clk, rst_n;
  logic scl, sda, mst, trs, wr_en, wr_b, wr_c;
  logic busy, s_req, s_rep, p_req, s_pend, p_pend;

  int checks = 0;
  int errors = 0;
  logic m_busy = 1'b0, m_spend = 1'b0, m_ppend = 1'b0;

  i2c_busy_monitor u_i2c_busy_monitor (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .master_i(mst), .transmit_i(trs), .wr_en_i(wr_en),
    .wr_busy_i(wr_b), .wr_sclctl_i(wr_c), .bus_busy_o(busy),
    .start_req_o(s_req), .start_rep_o(s_rep), .stop_req_o(p_req),
    .start_pend_o(s_pend), .stop_pend_o(p_pend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic exp_start(logic b, logic c, logic m, logic t);
    return !c && b && m && t;
  endfunction
  function automatic logic exp_stop(logic b, logic c, logic m);
    return !c && !b && m;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_lines(logic s, logic d);
    scl = s; sda = d;
    repeat (3) @(negedge clk);
  endtask

  // Bring SDA to the level needed before the edge, with SCL low.
  task automatic prep(logic d);
    if (sda !== d) begin
      set_lines(1'b0, sda);
      set_lines(1'b0, d);
      set_lines(1'b1, d);
      check("R4 busy held through SCL-low moves", busy, m_busy);
    end
  endtask

  task automatic bus_cond(logic is_start);
    prep(is_start);
    sda = ~is_start;
    repeat (2) @(negedge clk);
    check(is_start ? "R2 latency old value" : "R3 latency old value", busy, m_busy);
    @(negedge clk);
    m_busy = is_start;
    if (is_start) m_spend = 1'b0; else m_ppend = 1'b0;
    check(is_start ? "R2 busy set" : "R3 busy cleared", busy, m_busy);
    check("R11 start_pend", s_pend, m_spend);
    check("R11 stop_pend", p_pend, m_ppend);
  endtask

  task automatic wr(logic b, logic c, logic m, logic t);
    logic es, ep;
    es = exp_start(b, c, m, t);
    ep = exp_stop(b, c, m);
    mst = m; trs = t; wr_b = b; wr_c = c; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (es) m_spend = 1'b1;
    if (ep) m_ppend = 1'b1;
    check("R5 R8 R9 start_req", s_req, es);
    check("R6 start_rep", s_rep, es && m_busy);
    check("R7 R8 R9 stop_req", p_req, ep);
    check("R10 busy unchanged by write", busy, m_busy);
    check("R11 start_pend after write", s_pend, m_spend);
    check("R11 stop_pend after write", p_pend, m_ppend);
    @(negedge clk);
    check("R5 start pulse one cycle", s_req, 1'b0);
    check("R7 stop pulse one cycle", p_req, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    mst = 1'b0; trs = 1'b0; wr_en = 1'b0; wr_b = 1'b0; wr_c = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 busy reset", busy, 1'b0);
    check("R1 start_req reset", s_req, 1'b0);
    check("R1 start_rep reset", s_rep, 1'b0);
    check("R1 stop_req reset", p_req, 1'b0);
    check("R1 start_pend reset", s_pend, 1'b0);
    check("R1 stop_pend reset", p_pend, 1'b0);

    // Directed cases.
    wr(1'b1, 1'b0, 1'b0, 1'b1);   // R8 slave start ignored
    wr(1'b1, 1'b0, 1'b1, 1'b0);   // R8 master receive start ignored
    wr(1'b1, 1'b1, 1'b1, 1'b1);   // R9 clock-hold set
    wr(1'b0, 1'b1, 1'b1, 1'b1);   // R9 clock-hold set, stop shape
    wr(1'b1, 1'b0, 1'b1, 1'b1);   // R5 start on free bus
    bus_cond(1'b1);               // R2, R11 clear
    wr(1'b1, 1'b0, 1'b1, 1'b1);   // R6 repeated start
    bus_cond(1'b1);               // repeated start on bus
    wr(1'b0, 1'b0, 1'b0, 1'b0);   // R8 slave stop ignored
    wr(1'b0, 1'b0, 1'b1, 1'b0);   // R7 stop in master receive
    bus_cond(1'b0);               // R3, R11 clear
    set_lines(1'b0, 1'b1);        // R4 SCL falls, no condition
    set_lines(1'b0, 1'b0);
    set_lines(1'b0, 1'b1);
    check("R4 SDA moves with SCL low", busy, m_busy);
    set_lines(1'b1, 1'b1);
    check("R4 SCL rise is no condition", busy, m_busy);

    // Random mix of writes and bus conditions.
    for (int i = 0; i < 80; i++) begin
      int r;
      r = $urandom % 5;
      if (r == 0)      bus_cond(1'b1);
      else if (r == 1) bus_cond(1'b0);
      else wr(1'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 4 != 0), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule